// File: doc/BRIEF.md
# DS1 Transmit Zero Code Suppression Stuffer

This block sits in the transmit path of a DS1 framer, ahead of signaling-bit robbing and the line encoder. Each accepted 8-bit channel octet is checked for the all-zero pattern. When suppression applies to that channel, one bit is forced to logic 1, so the line never carries a long run of zeros from that octet. Every octet, changed or not, comes out one clock later with a valid strobe and the index of its channel.

The channel index is counted inside the block. A frame-start strobe that comes with an octet marks that octet as channel 0. Each further accepted octet moves the index on by one, and after channel 23 it returns to 0. A 24-bit per-channel table marks the channels that carry robbed-bit signaling.

The block has two modes. In the default mode, only marked channels are stuffed, and the stuffed bit is bit 7 when bits are numbered 1 (MSB) to 8 (LSB). Asserting the framer-mode input or the transmit-signaling input selects full suppression. In full suppression every channel is covered. Unmarked channels get their LSB forced, which leaves 56 of their 64 kbit/s usable. Marked channels still get bit 7, because the LSB of those channels is later overwritten by signaling. The table and both mode inputs are registered once before use.

Top module: `ds1_zcs_stuffer`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_octet is 0. The first octet accepted after reset is reported as channel 0, even when in_frame_start is not asserted.
- R2: A non-zero octet accepted on in_valid appears unchanged on out_octet on the next clock edge, with out_valid high for exactly that one cycle.
- R3: In default mode (framer_mode=0 and tx_sig=0), an all-zero octet in a channel whose table bit is 1 is output as 8'h02. This sets bit 7, which is out_octet[1].
- R4: In default mode, an all-zero octet in a channel whose table bit is 0 is output as 8'h00.
- R5: With framer_mode=1, an all-zero octet in a channel whose table bit is 0 is output as 8'h01. This sets the LSB, out_octet[0].
- R6: With tx_sig=1 and framer_mode=0, suppression behaves exactly as in R5 and R7.
- R7: In full suppression, an all-zero octet in a channel whose table bit is 1 is output as 8'h02.
- R8: An octet accepted with in_frame_start high is reported as channel 0. Each later accepted octet is reported with the previous index plus one, and the index after 23 is 0. rbs_en_tbl bit n belongs to channel n.
- R9: The table and mode values applied to an octet are those present on the inputs one clock before the octet is accepted. A change made in the same cycle as the octet does not affect it.
- R10: A cycle without in_valid produces out_valid=0 on the next cycle and does not advance the channel index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An octet is presented this cycle |
| in_frame_start | input | 1 | The presented octet is channel 0 |
| in_octet | input | 8 | Channel octet, bit 1 (MSB) at index 7 |
| rbs_en_tbl | input | 24 | Per-channel robbed-bit signaling marks, bit n for channel n |
| framer_mode | input | 1 | Selects full suppression |
| tx_sig | input | 1 | Transmit-signaling select; 1 also selects full suppression |
| out_valid | output | 1 | Output octet valid |
| out_octet | output | 8 | Octet after suppression |
| out_slot | output | 5 | Channel index of out_octet |

## Verification
A wrong channel count is the most likely hidden fault. It sends table lookups to the wrong channel, so a zero octet comes out as 8'h00 where 8'h02 is expected, or the other way round. out_slot shows the fault on the very next output cycle. A fault in the registered mode or table copy appears one octet after the setting changes: a zero octet then carries its stuffed bit in the wrong position. Every octet is checked in the cycle after it is accepted, so any fault is reported within one clock of the octet that exposes it.

// File: rtl/zcs_pkg.sv
// Package: shared sizes and bit positions for the zero code suppression stuffer.
// Assumes bit 1 (MSB) of a channel octet sits at vector index OCT_W-1.
package zcs_pkg;
    localparam int OCT_W      = 8;
    localparam int NUM_SLOTS  = 24;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    // bit 7 of 8 (MSB numbered 1) is vector index 1
    localparam int RBS_BIT    = OCT_W - 7;
    // bit 8, the LSB
    localparam int FULL_BIT   = 0;

    typedef logic [OCT_W-1:0]  octet_t;
    typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/zcs_slot_counter.sv
// Module: channel index counter.
// Produces the index of the octet presented now. A frame-start strobe forces
// index 0. Each accepted octet moves the index on, returning to 0 after the last.
// Assumes frame_start is only meaningful together with adv.
module zcs_slot_counter #(
    parameter int NUM_SLOTS = 24,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              frame_start,
    output logic [SLOT_W-1:0] cur_slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] next_q;

    // index of the octet presented in this cycle
    always_comb begin
        cur_slot = frame_start ? '0 : next_q;
    end

    // hold the index the next accepted octet will get
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
        end else if (adv) begin
            next_q <= (cur_slot == LAST) ? '0 : cur_slot + 1'b1;
        end
    end
endmodule

// File: rtl/zcs_cfg_shadow.sv
// Module: registered copy of the per-channel signaling marks and the mode select.
// Each mark has its own flop, built by a generate loop. Reset clears every mark
// and selects the default mode. Values reach the stuffer one clock after the inputs.
module zcs_cfg_shadow #(
    parameter int NUM_SLOTS = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] tbl_in,
    input  logic                 framer_mode,
    input  logic                 tx_sig,
    output logic [NUM_SLOTS-1:0] tbl_q,
    output logic                 full_q
);
    // one flop per channel mark
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mark
        always_ff @(posedge clk) begin
            if (!rst_n) tbl_q[g] <= 1'b0;
            else        tbl_q[g] <= tbl_in[g];
        end
    end

    // full suppression when either mode input selects it
    always_ff @(posedge clk) begin
        if (!rst_n) full_q <= 1'b0;
        else        full_q <= framer_mode | tx_sig;
    end
endmodule

// File: rtl/zcs_octet_stuffer.sv
// Module: decides whether to stuff an octet and which bit, then registers it.
// Assumes rbs is the signaling mark of the current channel and full selects
// full suppression. Only all-zero octets are changed.
module zcs_octet_stuffer
    import zcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    input  octet_t in_octet,
    input  slot_t  in_slot,
    input  logic   rbs,
    input  logic   full,
    output logic   out_valid,
    output octet_t out_octet,
    output slot_t  out_slot
);
    octet_t stuff_mask;
    logic   all_zero;

    // choose the bit to force for an all-zero octet
    always_comb begin
        all_zero   = (in_octet == '0);
        stuff_mask = '0;
        if (all_zero) begin
            if (rbs)       stuff_mask[RBS_BIT]  = 1'b1;
            else if (full) stuff_mask[FULL_BIT] = 1'b1;
        end
    end

    // register the result with its valid strobe and channel index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_octet <= '0;
            out_slot  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_octet <= in_octet | stuff_mask;
                out_slot  <= in_slot;
            end
        end
    end
endmodule

// File: rtl/ds1_zcs_stuffer.sv
// Module: top of the DS1 transmit zero code suppression stuffer.
// Counts channels, keeps a registered copy of the signaling marks and mode,
// and stuffs all-zero octets with one clock of latency.
// Assumes one octet per cycle at most, with in_frame_start on channel 0.
module ds1_zcs_stuffer
    import zcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_frame_start,
    input  logic [OCT_W-1:0]     in_octet,
    input  logic [NUM_SLOTS-1:0] rbs_en_tbl,
    input  logic                 framer_mode,
    input  logic                 tx_sig,
    output logic                 out_valid,
    output logic [OCT_W-1:0]     out_octet,
    output logic [SLOT_W-1:0]    out_slot
);
    slot_t                cur_slot;
    logic [NUM_SLOTS-1:0] tbl_q;
    logic                 full_q;
    logic                 cur_rbs;

    zcs_slot_counter #(.NUM_SLOTS(NUM_SLOTS)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (in_valid),
        .frame_start(in_frame_start & in_valid),
        .cur_slot   (cur_slot)
    );

    zcs_cfg_shadow #(.NUM_SLOTS(NUM_SLOTS)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .tbl_in     (rbs_en_tbl),
        .framer_mode(framer_mode),
        .tx_sig     (tx_sig),
        .tbl_q      (tbl_q),
        .full_q     (full_q)
    );

    // look up the mark for the current channel
    always_comb begin
        cur_rbs = tbl_q[cur_slot];
    end

    zcs_octet_stuffer u_stuff (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_octet (in_octet),
        .in_slot  (cur_slot),
        .rbs      (cur_rbs),
        .full     (full_q),
        .out_valid(out_valid),
        .out_octet(out_octet),
        .out_slot (out_slot)
    );
endmodule

// File: rtl/zcs_checker.sv
// Module: port-level properties of the stuffer, attached by bind.
module zcs_checker
    import zcs_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_frame_start,
    input logic [OCT_W-1:0]   in_octet,
    input logic               out_valid,
    input logic [OCT_W-1:0]   out_octet,
    input logic [SLOT_W-1:0]  out_slot
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_no_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_nonzero_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_octet != '0) |=> (out_octet == $past(in_octet)));

    // a zero octet leaves with at most one of the two low bits set (R3, R4, R5, R7)
    assert_zero_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_octet == '0) |=>
            ($countones(out_octet) <= 1 && out_octet[OCT_W-1:2] == '0));

    assert_frame_start_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_frame_start) |=> (out_slot == '0));

    assert_slot_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_slot <= SLOT_W'(NUM_SLOTS - 1)));
endmodule

bind ds1_zcs_stuffer zcs_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_frame_start(in_frame_start),
    .in_octet      (in_octet),
    .out_valid     (out_valid),
    .out_octet     (out_octet),
    .out_slot      (out_slot)
);

// File: tb/ds1_zcs_stuffer_tb.sv
// Directed bench for the zero code suppression stuffer.
module ds1_zcs_stuffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_frame_start = 1'b0;
    logic [7:0]  in_octet = 8'h00;
    logic [23:0] rbs_en_tbl = 24'h0;
    logic        framer_mode = 1'b0;
    logic        tx_sig = 1'b0;
    logic        out_valid;
    logic [7:0]  out_octet;
    logic [4:0]  out_slot;

    int n_chk = 0;
    int n_bad = 0;
    int bslot = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ds1_zcs_stuffer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame_start(in_frame_start),
        .in_octet(in_octet), .rbs_en_tbl(rbs_en_tbl), .framer_mode(framer_mode),
        .tx_sig(tx_sig), .out_valid(out_valid), .out_octet(out_octet), .out_slot(out_slot)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // expected octet from the requirements; tbl and full are the values set a cycle earlier
    function automatic logic [7:0] model(input logic [7:0] o, input bit rbs, input bit full);
        if (o != 8'h00) return o;
        if (rbs)        return 8'h02;
        if (full)       return 8'h01;
        return 8'h00;
    endfunction

    // drive one octet at a falling edge, check the result one falling edge later
    task automatic send(input string tag, input logic [7:0] o, input bit fs,
                        input bit rbs, input bit full);
        int cur;
        cur = fs ? 0 : bslot;
        bslot = (cur == 23) ? 0 : cur + 1;
        in_valid = 1'b1; in_frame_start = fs; in_octet = o;
        @(negedge clk);
        in_valid = 1'b0; in_frame_start = 1'b0;
        check(tag, "out_valid", int'(out_valid), 1);
        check(tag, "out_octet", int'(out_octet), int'(model(o, rbs, full)));
        check(tag, "out_slot", int'(out_slot), cur);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "out_octet in reset", int'(out_octet), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        bslot = 0;
        send("R1", 8'h5A, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_pass_and_wrap();
        // non-zero octets, index runs past 23 and wraps (R2, R8)
        for (int i = 0; i < 30; i++) send("R8", 8'(i * 7 + 1), 1'b0, 1'b0, 1'b0);
        send("R8", 8'hFF, 1'b1, 1'b0, 1'b0);
        send("R2", 8'h80, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_idle();
        // idle cycles: no output, no index advance (R10)
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10", "out_valid idle", int'(out_valid), 0);
        end
        send("R10", 8'h33, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic run_frame(input string tag, input logic [23:0] tbl, input bit full);
        for (int s = 0; s < 24; s++)
            send(tag, 8'h00, (s == 0), tbl[s], full);
    endtask

    task automatic t_default();
        rbs_en_tbl = 24'hA5C3F0; framer_mode = 1'b0; tx_sig = 1'b0;
        settle();
        run_frame("R3", 24'hA5C3F0, 1'b0);
        rbs_en_tbl = 24'h000000;
        settle();
        run_frame("R4", 24'h000000, 1'b0);
    endtask

    task automatic t_full();
        rbs_en_tbl = 24'h0F0F11; framer_mode = 1'b1; tx_sig = 1'b0;
        settle();
        run_frame("R5", 24'h0F0F11, 1'b1);
        rbs_en_tbl = 24'hFFFFFF;
        settle();
        run_frame("R7", 24'hFFFFFF, 1'b1);
        rbs_en_tbl = 24'h3C0081; framer_mode = 1'b0; tx_sig = 1'b1;
        settle();
        run_frame("R6", 24'h3C0081, 1'b1);
        tx_sig = 1'b0;
        settle();
    endtask

    task automatic t_sample();
        // a change made in the octet's own cycle applies only from the next octet (R9)
        rbs_en_tbl = 24'h0; framer_mode = 1'b0; tx_sig = 1'b0;
        settle();
        rbs_en_tbl = 24'hFFFFFF; framer_mode = 1'b1;
        send("R9", 8'h00, 1'b1, 1'b0, 1'b0);
        send("R9", 8'h00, 1'b0, 1'b1, 1'b1);
        rbs_en_tbl = 24'h0;
        send("R9", 8'h00, 1'b0, 1'b1, 1'b1);
        send("R9", 8'h00, 1'b0, 1'b0, 1'b1);
        framer_mode = 1'b0;
        send("R9", 8'h00, 1'b0, 1'b0, 1'b1);
        send("R9", 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_pass_and_wrap();
        t_idle();
        t_default();
        t_full();
        t_sample();
        finish_run();
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end
endmodule